// File: doc/BRIEF.md
# Masked-Address GPIO Register Port

This block is an eight-pin general-purpose I/O port behind a simple 32-bit read/write register bus with a 4 KB address window. The pin data register is not at one fixed offset. Every word offset below 0x400 reaches it, and byte-address bits [9:2] of the access act as a per-pin mask. A single read can therefore return any chosen subset of pins, with the other bits forced to zero. A single write can update any chosen subset of output pins without a read-modify-write sequence.

Beside the data register, the port holds a direction register, nine pad-configuration registers, and an alternate-function select register. The alternate-function register is protected by a commit mask, and that mask can only be rewritten after a 32-bit unlock key has been written to the lock register. Twelve read-only identification bytes sit at the top of the window. Any other offset is undecoded: reads there return zero, writes there are dropped, and a one-cycle error pulse is raised.

Each pin set as an output drives its data bit. Each pin set as an input drives its output line high, and its data bit follows the input pin on every clock. Register writes take effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read strobe.

Top module: `mgpio_port`

## Requirements
- R1: After reset the following hold. Direction is 0x00, so every pin_out bit is 1. Data is 0x00 and alternate-function select is 0x00. The commit mask is 0xFF and the lock flag reads 1. The 2 mA drive register (0x500) is 0xFF, the other pad registers are 0x00, and bus_rdata is 0.
- R2: A read at any byte address below 0x400 returns the data register ANDed with address bits [9:2]. Bits [31:8] of the result are 0.
- R3: A write at any byte address below 0x400 changes only the data bits whose mask bit (address bit [9:2]) and direction bit are both 1. All other data bits keep their value.
- R4: For each pin i, pin_out[i] equals data[i] when direction[i] is 1 and equals 1 when direction[i] is 0. The direction register is at 0x400, and bit i set to 1 makes pin i an output.
- R5: While direction[i] is 0, data[i] takes the value of pin_in[i] at every clock edge. While direction[i] is 1, pin_in[i] has no effect on data[i].
- R6: The lock flag is read at 0x520 as bit 0. Writing the 32-bit key 0x0ACCE551 to 0x520 clears the flag, and writing any other value sets it.
- R7: A write to the commit mask at 0x524 stores bits [7:0] only while the lock flag is 0. While the flag is 1, such a write leaves the mask unchanged.
- R8: A write to alternate-function select at 0x420 changes only the bits that are 1 in the commit mask.
- R9: Each of the nine pad registers stores bits [7:0] of a write and reads back those 8 bits with bits [31:8] as 0. They sit at 0x500, 0x504, 0x508, 0x50C, 0x510, 0x514, 0x518, 0x51C and 0x528.
- R10: The words at 0xFD0, 0xFD4, ... up to 0xFFC return, in address order, the bytes 00 00 00 00 61 00 18 01 0D F0 05 B1 in bits [7:0].
- R11: Offsets 0x404–0x41C, 0x424–0x4FC and 0x52C–0xFCC are undecoded. Reads there return 0, writes there change no register, and bus_err is 1 for exactly the one cycle after the access. Decoded accesses never raise bus_err.
- R12: bus_rdata changes only in the cycle after a read strobe. In all other cycles it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse after an access to an undecoded offset |
| pin_in | input | 8 | Input levels from the pins |
| pin_out | output | 8 | Resolved output levels to the pins |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle, and that each strobe refers to the address and write data present in that cycle. The bench drives every bus access from one task at the falling clock edge. Each access raises exactly one strobe, and the bench changes pin_in only between accesses. As a result, each input level is held across at least one rising edge before the data register is read. The randomized stretch draws its offsets from the data window, the direction register and the pad registers. The undecoded ranges are reached through directed accesses at their edges and in their interiors.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

   // Register selector produced by the address decoder.
   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_DATA   = 3'd1,
      SEL_DIR    = 3'd2,
      SEL_ALT    = 3'd3,
      SEL_PAD    = 3'd4,
      SEL_LOCK   = 3'd5,
      SEL_COMMIT = 3'd6,
      SEL_ID     = 3'd7
   } sel_e;

   // Number of pad-configuration registers.
   localparam int NUM_PAD   = 9;
   localparam int PAD_IDX_W = 4;
   localparam int ID_BYTES  = 12;

   // Word indices (byte offset / 4) of the decoded registers.
   localparam logic [9:0] W_DATA_END = 10'h100;
   localparam logic [9:0] W_DIR      = 10'h100;
   localparam logic [9:0] W_ALT      = 10'h108;
   localparam logic [9:0] W_PAD0     = 10'h140;
   localparam logic [9:0] W_PAD7     = 10'h147;
   localparam logic [9:0] W_LOCK     = 10'h148;
   localparam logic [9:0] W_COMMIT   = 10'h149;
   localparam logic [9:0] W_ANALOG   = 10'h14A;
   localparam logic [9:0] W_ID0      = 10'h3F4;

   typedef struct packed {
      sel_e                 sel;
      logic [PAD_IDX_W-1:0] pad;
      logic [3:0]           idb;
   } dec_t;

   // Identification byte for index 0..11.
   function automatic logic [7:0] id_byte(input logic [3:0] idx);
      logic [7:0] b;
      case (idx)
         4'd4:    b = 8'h61;
         4'd6:    b = 8'h18;
         4'd7:    b = 8'h01;
         4'd8:    b = 8'h0D;
         4'd9:    b = 8'hF0;
         4'd10:   b = 8'h05;
         4'd11:   b = 8'hB1;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

   // Pad register 0 (2 mA drive) comes out of reset all ones.
   function automatic logic pad_resets_high(input int idx);
      return idx == 0;
   endfunction

endpackage

// File: rtl/mgp_decode.sv
module mgp_decode
   import mgp_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic [1:0]        unused_byte_lane;

   assign word             = addr[ADDR_W-1:2];
   assign unused_byte_lane = addr[1:0];

   always_comb begin
      dec     = '0;
      dec.sel = SEL_NONE;
      if (word < W_DATA_END) begin
         dec.sel = SEL_DATA;
      end else if (word == W_DIR) begin
         dec.sel = SEL_DIR;
      end else if (word == W_ALT) begin
         dec.sel = SEL_ALT;
      end else if (word >= W_PAD0 && word <= W_PAD7) begin
         dec.sel = SEL_PAD;
         dec.pad = PAD_IDX_W'(word - W_PAD0);
      end else if (word == W_ANALOG) begin
         dec.sel = SEL_PAD;
         dec.pad = PAD_IDX_W'(NUM_PAD - 1);
      end else if (word == W_LOCK) begin
         dec.sel = SEL_LOCK;
      end else if (word == W_COMMIT) begin
         dec.sel = SEL_COMMIT;
      end else if (word >= W_ID0) begin
         dec.sel = SEL_ID;
         dec.idb = word[3:0] - 4'd4;
      end
   end

endmodule

// File: rtl/mgp_cfg.sv
module mgp_cfg
   import mgp_pkg::*;
#(
   parameter int                PINS     = 8,
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] LOCK_KEY = DATA_W'(32'h0ACC_E551)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  dec_t                           dec,
   input  logic [DATA_W-1:0]              wdata,
   output logic [PINS-1:0]                dir_q,
   output logic [PINS-1:0]                alt_q,
   output logic [PINS-1:0]                commit_q,
   output logic                           lock_q,
   output logic [NUM_PAD-1:0][PINS-1:0]   pad_q
);

   logic [PINS-1:0] wbits;
   logic            wr_dir, wr_alt, wr_lock, wr_commit;

   assign wbits     = wdata[PINS-1:0];
   assign wr_dir    = wr && (dec.sel == SEL_DIR);
   assign wr_alt    = wr && (dec.sel == SEL_ALT);
   assign wr_lock   = wr && (dec.sel == SEL_LOCK);
   assign wr_commit = wr && (dec.sel == SEL_COMMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wbits;
      end
   end

   // Guard: the key register and the commit mask it protects.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q   <= 1'b1;
         commit_q <= '1;
      end else begin
         if (wr_lock) begin
            lock_q <= (wdata != LOCK_KEY);
         end
         if (wr_commit && !lock_q) begin
            commit_q <= wbits;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alt_q <= '0;
      end else if (wr_alt) begin
         alt_q <= (alt_q & ~commit_q) | (wbits & commit_q);
      end
   end

   for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad
      localparam logic [PINS-1:0] RST_VAL = pad_resets_high(p) ? '1 : '0;
      logic hit;
      assign hit = wr && (dec.sel == SEL_PAD) && (int'(dec.pad) == p);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pad_q[p] <= RST_VAL;
         end else if (hit) begin
            pad_q[p] <= wbits;
         end
      end
   end

endmodule

// File: rtl/mgp_data.sv
module mgp_data #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [PINS-1:0] wmask,
   input  logic [PINS-1:0] wbits,
   input  logic [PINS-1:0] dir,
   input  logic [PINS-1:0] pin_in,
   output logic [PINS-1:0] data_q,
   output logic [PINS-1:0] pin_out
);

   // One storage bit per pin: it holds the output value or the sampled input.
   for (genvar i = 0; i < PINS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[i] <= 1'b0;
         end else if (!dir[i]) begin
            data_q[i] <= pin_in[i];
         end else if (wr_en && wmask[i]) begin
            data_q[i] <= wbits[i];
         end
      end
      assign pin_out[i] = dir[i] ? data_q[i] : 1'b1;
   end

endmodule

// File: rtl/mgp_resp.sv
module mgp_resp
   import mgp_pkg::*;
#(
   parameter int PINS   = 8,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd,
   input  logic                         wr,
   input  dec_t                         dec,
   input  logic [PINS-1:0]              rmask,
   input  logic [PINS-1:0]              data_q,
   input  logic [PINS-1:0]              dir_q,
   input  logic [PINS-1:0]              alt_q,
   input  logic [PINS-1:0]              commit_q,
   input  logic                         lock_q,
   input  logic [NUM_PAD-1:0][PINS-1:0] pad_q,
   output logic [DATA_W-1:0]            rdata,
   output logic                         err
);

   logic [DATA_W-1:0] rnext;

   always_comb begin
      rnext = '0;
      unique case (dec.sel)
         SEL_DATA:   rnext[PINS-1:0] = data_q & rmask;
         SEL_DIR:    rnext[PINS-1:0] = dir_q;
         SEL_ALT:    rnext[PINS-1:0] = alt_q;
         SEL_PAD: begin
            if (int'(dec.pad) < NUM_PAD) begin
               rnext[PINS-1:0] = pad_q[dec.pad];
            end
         end
         SEL_LOCK:   rnext[0]        = lock_q;
         SEL_COMMIT: rnext[PINS-1:0] = commit_q;
         SEL_ID:     rnext[7:0]      = id_byte(dec.idb);
         default:    rnext           = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         if (rd) begin
            rdata <= rnext;
         end
         err <= (rd || wr) && (dec.sel == SEL_NONE);
      end
   end

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
   import mgp_pkg::*;
#(
   parameter int                PINS     = 8,
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 12,
   parameter logic [DATA_W-1:0] LOCK_KEY = DATA_W'(32'h0ACC_E551)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out
);

   localparam int MASK_LO = 2;
   localparam int MASK_HI = MASK_LO + PINS - 1;

   // Elaboration-time parameter checks.
   if (PINS < 1 || PINS > 8) begin : g_bad_pins
      $error("mgpio_port: PINS must be 1..8");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("mgpio_port: ADDR_W must be 12 (4 KB window)");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("mgpio_port: DATA_W must be at least 32");
   end

   dec_t                         dec;
   logic [PINS-1:0]              amask;
   logic [PINS-1:0]              data_q, dir_q, alt_q, commit_q;
   logic                         lock_q;
   logic [NUM_PAD-1:0][PINS-1:0] pad_q;
   logic                         wr_data;

   assign amask   = bus_addr[MASK_HI:MASK_LO];
   assign wr_data = bus_wr && (dec.sel == SEL_DATA);

   mgp_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   mgp_cfg #(.PINS(PINS), .DATA_W(DATA_W), .LOCK_KEY(LOCK_KEY)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .dec      (dec),
      .wdata    (bus_wdata),
      .dir_q    (dir_q),
      .alt_q    (alt_q),
      .commit_q (commit_q),
      .lock_q   (lock_q),
      .pad_q    (pad_q)
   );

   mgp_data #(.PINS(PINS)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_data),
      .wmask   (amask),
      .wbits   (bus_wdata[PINS-1:0]),
      .dir     (dir_q),
      .pin_in  (pin_in),
      .data_q  (data_q),
      .pin_out (pin_out)
   );

   mgp_resp #(.PINS(PINS), .DATA_W(DATA_W)) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd),
      .wr       (bus_wr),
      .dec      (dec),
      .rmask    (amask),
      .data_q   (data_q),
      .dir_q    (dir_q),
      .alt_q    (alt_q),
      .commit_q (commit_q),
      .lock_q   (lock_q),
      .pad_q    (pad_q),
      .rdata    (bus_rdata),
      .err      (bus_err)
   );

endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk #(
   parameter int                PINS     = 8,
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 12,
   parameter logic [DATA_W-1:0] LOCK_KEY = DATA_W'(32'h0ACC_E551)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   data_q,
   input logic [PINS-1:0]   dir_q,
   input logic [PINS-1:0]   alt_q,
   input logic [PINS-1:0]   commit_q,
   input logic              lock_q
);

   // live_q is set once a full clock has passed out of reset, so $past is meaningful.
   logic            live_q;
   logic            wr_data, wr_lock;
   logic [PINS-1:0] wmsk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assign wr_data = bus_wr && (bus_addr[ADDR_W-1:10] == '0);
   assign wr_lock = bus_wr && (bus_addr[ADDR_W-1:2] == 10'h148);
   assign wmsk    = bus_addr[PINS+1:2] & dir_q;

   a_in_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R3: masked write reaches exactly the masked output pins
   a_r3_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(wr_data) |->
         ((pin_out & $past(wmsk)) == ($past(bus_wdata[PINS-1:0]) & $past(wmsk))));

   // R5: input pins are captured into the data register
   a_r5_input_capture: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> ((data_q & ~$past(dir_q)) == ($past(pin_in) & ~$past(dir_q))));

   // R6: the lock flag follows the key comparison
   a_r6_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(wr_lock) |-> (lock_q == ($past(bus_wdata) != LOCK_KEY)));

   // R7: commit mask frozen while locked
   a_r7_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(lock_q) |-> $stable(commit_q));

   // R8: alternate-function bits move only under the commit mask
   a_r8_alt_under_commit: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0));

   // R11: an error pulse always follows an access
   a_r11_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && bus_err |-> $past(bus_rd || bus_wr));

   // R12: read data holds when no read was issued
   a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind mgpio_port mgpio_port_chk #(
   .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_KEY(LOCK_KEY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .data_q    (data_q),
   .dir_q     (dir_q),
   .alt_q     (alt_q),
   .commit_q  (commit_q),
   .lock_q    (lock_q)
);

// File: tb/sim_mgpio_port.sv
`timescale 1ns/1ps
module sim_mgpio_port;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   // Bench model of the visible register state.
   logic [7:0] m_data, m_dir, m_alt, m_commit;
   logic       m_lock;
   logic [7:0] m_pad [9];

   mgpio_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .pin_in    (pin_in),
      .pin_out   (pin_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [11:0] pad_addr(input int i);
      return (i < 8) ? 12'(12'h500 + 4*i) : 12'h528;
   endfunction

   function automatic logic [7:0] id_exp(input int i);
      logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                             8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      return t[i];
   endfunction

   function automatic logic [7:0] exp_pins();
      return (m_data & m_dir) | ~m_dir;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      e = bus_err;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
      e = bus_err;
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
      m_data = (m_data & m_dir) | (v & ~m_dir);
   endtask

   task automatic write_dir(input logic [7:0] v);
      logic e;
      bus_write(12'h400, {24'h0, v}, e);
      m_dir  = v;
      m_data = (m_data & m_dir) | (pin_in & ~m_dir);
      chk("R4 pin_out after direction write", {24'h0, pin_out}, {24'h0, exp_pins()});
   endtask

   task automatic write_data(input logic [11:0] a, input logic [7:0] v);
      logic       e;
      logic [7:0] m;
      bus_write(a, {24'hA5A5A5, v}, e);
      m      = a[9:2] & m_dir;
      m_data = (m_data & ~m) | (v & m);
      chk("R3 pin_out after masked data write", {24'h0, pin_out}, {24'h0, exp_pins()});
   endtask

   task automatic read_data(input logic [11:0] a);
      logic [31:0] d;
      logic        e;
      bus_read(a, d, e);
      chk("R2 masked data read", d, {24'h0, m_data & a[9:2]});
   endtask

   task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      logic        e;
      bus_read(a, d, e);
      chk(tag, d, exp);
      chk("R11 no error on decoded read", {31'h0, e}, 32'h0);
   endtask

   task automatic check_all_cfg(input string tag);
      expect_reg({tag, " direction"}, 12'h400, {24'h0, m_dir});
      expect_reg({tag, " alt select"}, 12'h420, {24'h0, m_alt});
      expect_reg({tag, " commit"}, 12'h524, {24'h0, m_commit});
      expect_reg({tag, " lock"}, 12'h520, {31'h0, m_lock});
      for (int i = 0; i < 9; i++) begin
         expect_reg({tag, " pad"}, pad_addr(i), {24'h0, m_pad[i]});
      end
   endtask

   task automatic undecoded(input logic [11:0] a, input bit is_wr);
      logic [31:0] d;
      logic        e;
      if (is_wr) begin
         bus_write(a, 32'hFFFF_FFFF, e);
      end else begin
         bus_read(a, d, e);
         chk("R11 undecoded read returns zero", d, 32'h0);
      end
      chk("R11 error pulse after undecoded access", {31'h0, e}, 32'h1);
      @(negedge clk);
      chk("R11 error pulse lasts one cycle", {31'h0, bus_err}, 32'h0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL all requirements (watchdog): actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        e;
      void'($urandom(32'd20240611));

      m_data = '0; m_dir = '0; m_alt = '0; m_commit = 8'hFF; m_lock = 1'b1;
      for (int i = 0; i < 9; i++) m_pad[i] = (i == 0) ? 8'hFF : 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pin_out after reset", {24'h0, pin_out}, 32'hFF);
      chk("R1 rdata after reset", bus_rdata, 32'h0);
      check_all_cfg("R1 reset value");
      read_data(12'h3FC);

      // R4 / R5 directed
      set_pins(8'h5A);
      read_data(12'h3FC);
      chk("R4 all inputs drive high", {24'h0, pin_out}, 32'hFF);
      write_dir(8'hF0);
      write_data(12'h3FC, 8'hFF);
      chk("R4 outputs high", {24'h0, pin_out}, 32'hFF);
      write_data(12'h0C0, 8'h00);
      chk("R3 only bits 4,5 cleared", {24'h0, pin_out}, 32'hCF);
      set_pins(8'h0F);
      read_data(12'h3FC);
      chk("R5 input bits follow, output bits ignore pins", {24'h0, pin_out}, 32'hCF);
      write_data(12'h03C, 8'h00);
      read_data(12'h3FC);
      read_data(12'h024);

      // R6 / R7 lock and commit
      bus_write(12'h524, 32'h0F, e);
      check_all_cfg("R7 commit unchanged while locked");
      bus_write(12'h520, 32'h0ACC_E551, e); m_lock = 1'b0;
      expect_reg("R6 key unlocks", 12'h520, 32'h0);
      bus_write(12'h524, 32'hFFFF_FF0F, e); m_commit = 8'h0F;
      expect_reg("R7 commit written while unlocked", 12'h524, 32'h0F);
      bus_write(12'h520, 32'h0ACC_E550, e); m_lock = 1'b1;
      expect_reg("R6 wrong key locks", 12'h520, 32'h1);
      bus_write(12'h524, 32'h33, e);
      expect_reg("R7 commit frozen after relock", 12'h524, 32'h0F);

      // R8 alternate function under commit mask
      bus_write(12'h420, 32'hFF, e); m_alt = 8'h0F;
      expect_reg("R8 alt limited by commit", 12'h420, 32'h0F);
      bus_write(12'h420, 32'hA0, e); m_alt = 8'h00;
      expect_reg("R8 alt committed bits cleared", 12'h420, 32'h00);
      bus_write(12'h420, 32'hA5, e); m_alt = 8'h05;
      expect_reg("R8 alt partial", 12'h420, 32'h05);

      // R9 pad registers
      for (int i = 0; i < 9; i++) begin
         logic [7:0] v;
         v = 8'($urandom);
         bus_write(pad_addr(i), {24'hFFFFFF, v}, e);
         m_pad[i] = v;
         chk("R11 no error on decoded write", {31'h0, e}, 32'h0);
      end
      check_all_cfg("R9 pad readback");

      // R10 identification bytes
      for (int i = 0; i < 12; i++) begin
         expect_reg("R10 identification byte", 12'(12'hFD0 + 4*i), {24'h0, id_exp(i)});
      end

      // R11 undecoded offsets
      undecoded(12'h404, 1'b0);
      undecoded(12'h41C, 1'b0);
      undecoded(12'h424, 1'b0);
      undecoded(12'h4FC, 1'b0);
      undecoded(12'h52C, 1'b0);
      undecoded(12'h800, 1'b0);
      undecoded(12'hFCC, 1'b0);
      undecoded(12'h404, 1'b1);
      undecoded(12'h424, 1'b1);
      undecoded(12'h600, 1'b1);
      undecoded(12'hFCC, 1'b1);
      check_all_cfg("R11 registers unchanged by undecoded writes");
      read_data(12'h3FC);

      // R12 read data holds without a read
      bus_read(12'h400, d, e);
      repeat (3) @(negedge clk);
      chk("R12 rdata holds while idle", bus_rdata, {24'h0, m_dir});
      bus_write(12'h504, 32'h77, e); m_pad[1] = 8'h77;
      chk("R12 rdata holds across write", bus_rdata, {24'h0, m_dir});

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0: write_dir(8'($urandom));
            1: write_data({2'b00, 8'($urandom), 2'($urandom)}, 8'($urandom));
            2: set_pins(8'($urandom));
            3: read_data({2'b00, 8'($urandom), 2'($urandom)});
            4: begin
               int p;
               logic [7:0] v;
               p = int'($urandom_range(0, 8));
               v = 8'($urandom);
               bus_write(pad_addr(p), {24'h0, v}, e);
               m_pad[p] = v;
               expect_reg("R9 random pad readback", pad_addr(p), {24'h0, v});
            end
            default: chk("R4 random pin_out", {24'h0, pin_out}, {24'h0, exp_pins()});
         endcase
      end

      done = 1;
      summary();
      $finish;
   end

endmodule